// File: doc/BRIEF.md
# Routing-Matrix Serial Control Register Bank

This block is the digital control side of an audio/video routing matrix. An I2C slave running off the system clock takes six control bytes from a host and decodes them into select fields for the matrix. These fields cover two composite video outputs, two luma/chroma output pairs and three stereo audio outputs. The same bytes also carry the third audio channel's volume, mute and left/right routing, the group-delay settings, the sync-source choices and two open-drain logic bits. A read returns one status byte. That byte reports the two sync-present flags, a packed code for three tri-level mode detectors, and a flag that shows the register image is still at its reset values.

A write is made up of the slave address, then a subaddress byte, then any number of data bytes. The subaddress moves up by one after every data byte. A read returns the status byte once for every byte the host acknowledges, and a NACK from the host ends the read. The bus pins are sampled by the system clock through a synchroniser, so the system clock must run many times faster than SCL (SCL runs at up to 100 kHz).

Top module: `avsw_ctrl_regs`

## Requirements
- R1: The 7-bit slave address is {6'b100100, addr_sel}, which gives address bytes 0x90 or 0x92 for a write and 0x91 or 0x93 for a read. On an address match the block acknowledges. On any other address it does not acknowledge, and it ignores the transfer until the next START.
- R2: In a write, the first byte after the address is the subaddress. Each later data byte goes to control byte (subaddress + 1), and the subaddress then increments. Every data byte is acknowledged.
- R3: Data bytes at subaddress 6 or above are acknowledged but change no output.
- R4: Control byte 1 (subaddress 0): bits 7:4 drive cv1_sel and bits 3:0 drive cv2_sel. Codes 0..8 pick a source and code 9 means mute.
- R5: Control byte 2 (subaddress 1): bit 7 drives lo0, bit 6 drives lo1, bits 5:3 drive yc1_sel and bits 2:0 drive yc2_sel.
- R6: Control byte 3 (subaddress 2): bit 7 drives zc_en, bit 6 drives ch3_mute, bits 5:3 drive aud1_sel and bits 2:0 drive aud2_sel.
- R7: Control byte 4 (subaddress 3): bits 7:3 drive gd_val and bits 2:0 drive aud3_sel. Control byte 5 (subaddress 4): bits 7:5 drive vol_coarse, bits 4:2 drive vol_fine and bits 1:0 drive lr_route.
- R8: Control byte 6 (subaddress 5): bit 7 drives gd1_en, bit 6 drives gd2_en, bit 5 drives syncsrc1 and bit 4 drives syncsrc2. Bits 3:0 are discarded.
- R9: After reset the six control bytes read back through the outputs as 0x99, 0xFF, 0xFF, 0x87, 0xFC and 0xF0.
- R10: The status byte is {sync2, sync1, mode_code[4:0], por_flag}, MSB first. After an acknowledged read address the block sends it once per byte the host acknowledges. A NACK releases the bus.
- R11: mode_code = m1 + 3*m2 + 9*m3. Each mode input uses 0 for internal, 1 for external wide and 2 for external narrow, and the input value 3 counts as 2. The code never exceeds 26.
- R12: por_flag reads 1 after reset. It drops to 0 on the first data byte accepted into a control byte (subaddress 0..5) and stays at 0 until reset.
- R13: The control outputs change only in the cycle after an accepted in-range data byte. sda_oe changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| addr_sel | input | 1 | Slave address LSB |
| sync1_det | input | 1 | Sync present on path 1 |
| sync2_det | input | 1 | Sync present on path 2 |
| mode1 | input | 2 | Tri-level mode detector 1 |
| mode2 | input | 2 | Tri-level mode detector 2 |
| mode3 | input | 2 | Tri-level mode detector 3 |
| cv1_sel | output | 4 | Composite output 1 source |
| cv2_sel | output | 4 | Composite output 2 source |
| yc1_sel | output | 3 | Luma/chroma pair 1 source |
| yc2_sel | output | 3 | Luma/chroma pair 2 source |
| aud1_sel | output | 3 | Stereo output 1 source |
| aud2_sel | output | 3 | Stereo output 2 source |
| aud3_sel | output | 3 | Stereo output 3 source |
| zc_en | output | 1 | Zero-cross gating enable |
| ch3_mute | output | 1 | Channel 3 mute |
| gd_val | output | 5 | Group-delay adjustment |
| vol_coarse | output | 3 | Channel 3 coarse attenuation |
| vol_fine | output | 3 | Channel 3 fine attenuation |
| lr_route | output | 2 | Channel 3 left/right routing |
| gd1_en | output | 1 | Group delay 1 enable |
| gd2_en | output | 1 | Group delay 2 enable |
| syncsrc1 | output | 1 | Sync detector 1 source select |
| syncsrc2 | output | 1 | Sync detector 2 source select |
| lo0 | output | 1 | Logic output 0 |
| lo1 | output | 1 | Logic output 1 |

## Verification
The bench builds the block with SYNC_STAGES set to 3, one more than the default. This lengthens the path from a pin edge to the engine's reaction, and it checks that the ACK drive and the release of SDA still fall inside the SCL low phase. Each SCL quarter lasts 8 system clocks, the tightest margin the bench gives the engine. This is enough to bring in a repeated multi-byte read, subaddress wrap-around beyond the register bank, the input value 3 on all three mode detectors, and both settings of addr_sel.

// File: rtl/avsw_pkg.sv
package avsw_pkg;
  localparam int CTRL_BYTES = 6;
  typedef logic [7:0] byte_t;

  function automatic byte_t ctrl_default(input int idx);
    case (idx)
      0:       return 8'h99;
      1:       return 8'hFF;
      2:       return 8'hFF;
      3:       return 8'h87;
      4:       return 8'hFC;
      5:       return 8'hF0;
      default: return 8'h00;
    endcase
  endfunction

  function automatic byte_t ctrl_mask(input int idx);
    return (idx == 5) ? 8'hF0 : 8'hFF;
  endfunction

  function automatic logic [1:0] lvl_clamp(input logic [1:0] v);
    return (v == 2'b11) ? 2'b10 : v;
  endfunction
endpackage

// File: rtl/avsw_i2c_engine.sv
module avsw_i2c_engine #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [5:0]  ADDR_HI     = 6'b100100,
  parameter int          NREG        = 6,
  localparam int         IDX_W       = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             addr_sel,
  input  logic [7:0]       status_i,
  output logic             sda_oe,
  output logic             scl_s,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);
  localparam logic [7:0] NREG_B = 8'(NREG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_WACK, S_TX, S_RACK, S_RNXT} st_t;

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, sda_s;
  logic scl_rise, scl_fall, start_c, stop_c;
  st_t  st;
  logic [3:0] bitcnt;
  logic [7:0] sh, txsh, ptr;
  logic       rd, first;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[SYNC_STAGES-1];
  assign sda_s    = sda_pipe[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      bitcnt  <= '0;
      sh      <= '0;
      txsh    <= '0;
      ptr     <= '0;
      rd      <= 1'b0;
      first   <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_c) begin
        st     <= S_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        first  <= 1'b1;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_RX: begin
            if (scl_rise) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (st == S_ADDR) begin
                if (sh[7:1] == {ADDR_HI, addr_sel}) begin
                  sda_oe <= 1'b1;
                  rd     <= sh[0];
                  st     <= S_AACK;
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                st     <= S_WACK;
                if (first) begin
                  ptr   <= sh;
                  first <= 1'b0;
                end else begin
                  if (ptr < NREG_B) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= ptr[IDX_W-1:0];
                    wr_data <= sh;
                  end
                  if (ptr != 8'hFF) ptr <= ptr + 8'd1;
                end
              end
            end
          end
          S_AACK: if (scl_fall) begin
            bitcnt <= '0;
            if (rd) begin
              txsh   <= status_i;
              sda_oe <= ~status_i[7];
              st     <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_RX;
            end
          end
          S_WACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            st     <= S_RX;
          end
          S_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= S_RACK;
              end else begin
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
              end
            end
          end
          S_RACK: if (scl_rise) st <= sda_s ? S_IDLE : S_RNXT;
          S_RNXT: if (scl_fall) begin
            txsh   <= status_i;
            sda_oe <= ~status_i[7];
            bitcnt <= '0;
            st     <= S_TX;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/avsw_ctrl_bank.sv
module avsw_ctrl_bank
  import avsw_pkg::*;
#(
  parameter int  NREG  = CTRL_BYTES,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [7:0]           wr_data,
  output logic [NREG-1:0][7:0] regs,
  output logic                 por
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= ctrl_default(i);
      por <= 1'b1;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++)
        if (wr_idx == IDX_W'(i)) regs[i] <= wr_data & ctrl_mask(i);
      por <= 1'b0;
    end
  end
endmodule

// File: rtl/avsw_status.sv
module avsw_status
  import avsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sync1_det,
  input  logic       sync2_det,
  input  logic [1:0] mode1,
  input  logic [1:0] mode2,
  input  logic [1:0] mode3,
  input  logic       por,
  output logic [4:0] mode_code,
  output logic [7:0] status
);
  logic       s1_q, s2_q;
  logic [4:0] code_c;

  always_comb begin
    code_c = {3'b000, lvl_clamp(mode1)}
           + ({3'b000, lvl_clamp(mode2)} * 5'd3)
           + ({3'b000, lvl_clamp(mode3)} * 5'd9);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q      <= 1'b0;
      s2_q      <= 1'b0;
      mode_code <= '0;
      status    <= '0;
    end else begin
      s1_q      <= sync1_det;
      s2_q      <= sync2_det;
      mode_code <= code_c;
      status    <= {s2_q, s1_q, code_c, por};
    end
  end
endmodule

// File: rtl/avsw_ctrl_regs.sv
module avsw_ctrl_regs
  import avsw_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI     = 6'b100100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       addr_sel,
  input  logic       sync1_det,
  input  logic       sync2_det,
  input  logic [1:0] mode1,
  input  logic [1:0] mode2,
  input  logic [1:0] mode3,
  output logic [3:0] cv1_sel,
  output logic [3:0] cv2_sel,
  output logic [2:0] yc1_sel,
  output logic [2:0] yc2_sel,
  output logic [2:0] aud1_sel,
  output logic [2:0] aud2_sel,
  output logic [2:0] aud3_sel,
  output logic       zc_en,
  output logic       ch3_mute,
  output logic [4:0] gd_val,
  output logic [2:0] vol_coarse,
  output logic [2:0] vol_fine,
  output logic [1:0] lr_route,
  output logic       gd1_en,
  output logic       gd2_en,
  output logic       syncsrc1,
  output logic       syncsrc2,
  output logic       lo0,
  output logic       lo1
);
  localparam int NREG  = CTRL_BYTES;
  localparam int IDX_W = $clog2(NREG);

  logic                 scl_sync, wr_en, por;
  logic [IDX_W-1:0]     wr_idx;
  logic [7:0]           wr_data, status;
  logic [4:0]           mode_code;
  logic [NREG-1:0][7:0] regs;

  avsw_i2c_engine #(.SYNC_STAGES(SYNC_STAGES), .ADDR_HI(ADDR_HI), .NREG(NREG)) u_eng (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .addr_sel(addr_sel),
    .status_i(status), .sda_oe(sda_oe), .scl_s(scl_sync),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  avsw_ctrl_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .regs(regs), .por(por)
  );

  avsw_status u_stat (
    .clk(clk), .rst(rst), .sync1_det(sync1_det), .sync2_det(sync2_det),
    .mode1(mode1), .mode2(mode2), .mode3(mode3), .por(por),
    .mode_code(mode_code), .status(status)
  );

  assign cv1_sel    = regs[0][7:4];
  assign cv2_sel    = regs[0][3:0];
  assign lo0        = regs[1][7];
  assign lo1        = regs[1][6];
  assign yc1_sel    = regs[1][5:3];
  assign yc2_sel    = regs[1][2:0];
  assign zc_en      = regs[2][7];
  assign ch3_mute   = regs[2][6];
  assign aud1_sel   = regs[2][5:3];
  assign aud2_sel   = regs[2][2:0];
  assign gd_val     = regs[3][7:3];
  assign aud3_sel   = regs[3][2:0];
  assign vol_coarse = regs[4][7:5];
  assign vol_fine   = regs[4][4:2];
  assign lr_route   = regs[4][1:0];
  assign gd1_en     = regs[5][7];
  assign gd2_en     = regs[5][6];
  assign syncsrc1   = regs[5][5];
  assign syncsrc2   = regs[5][4];
endmodule

// File: rtl/avsw_ctrl_regs_chk.sv
module avsw_ctrl_regs_chk
  import avsw_pkg::*;
#(
  localparam int IDX_W = $clog2(CTRL_BYTES)
) (
  input logic             clk,
  input logic             rst,
  input logic             sda_oe,
  input logic             scl_s,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             por,
  input logic [4:0]       mode_code,
  input logic [43:0]      outs
);
  a_r13_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(outs));

  a_r13_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);

  a_r12_por_stays_clear: assert property (@(posedge clk) disable iff (rst)
    !por |=> !por);

  a_r12_por_clears_on_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !por);

  a_r11_mode_in_range: assert property (@(posedge clk) disable iff (rst)
    mode_code <= 5'd26);

  a_r3_write_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_idx) < CTRL_BYTES));
endmodule

bind avsw_ctrl_regs avsw_ctrl_regs_chk u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_s(scl_sync), .wr_en(wr_en),
  .wr_idx(wr_idx), .por(por), .mode_code(mode_code),
  .outs({cv1_sel, cv2_sel, lo0, lo1, yc1_sel, yc2_sel, zc_en, ch3_mute,
         aud1_sel, aud2_sel, gd_val, aud3_sel, vol_coarse, vol_fine, lr_route,
         gd1_en, gd2_en, syncsrc1, syncsrc2})
);

// File: tb/sim_avsw_ctrl_regs.sv
module sim_avsw_ctrl_regs;
  localparam int Q = 8;
  localparam int NV = 10;
  // each entry: {subaddress, data}
  localparam logic [15:0] VEC [NV] = '{
    {8'd0, 8'h12}, {8'd1, 8'h2C}, {8'd2, 8'h4A}, {8'd3, 8'hF3}, {8'd4, 8'h5D},
    {8'd5, 8'h6F}, {8'd6, 8'hAA}, {8'd0, 8'h89}, {8'd200, 8'h00}, {8'd3, 8'h00}
  };

  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sync1_det = 1'b0, sync2_det = 1'b0;
  logic [1:0] mode1 = 2'd0, mode2 = 2'd0, mode3 = 2'd0;
  logic sda_oe, zc_en, ch3_mute, gd1_en, gd2_en, syncsrc1, syncsrc2, lo0, lo1;
  logic [3:0] cv1_sel, cv2_sel;
  logic [2:0] yc1_sel, yc2_sel, aud1_sel, aud2_sel, aud3_sel, vol_coarse, vol_fine;
  logic [4:0] gd_val;
  logic [1:0] lr_route;
  logic sda_bus;
  int n_chk = 0, n_bad = 0;
  logic [7:0] mdl [6];

  assign sda_bus = sda_m & ~sda_oe;
  always #10 clk = ~clk;

  avsw_ctrl_regs #(.SYNC_STAGES(3)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .sync1_det(sync1_det), .sync2_det(sync2_det),
    .mode1(mode1), .mode2(mode2), .mode3(mode3),
    .cv1_sel(cv1_sel), .cv2_sel(cv2_sel), .yc1_sel(yc1_sel), .yc2_sel(yc2_sel),
    .aud1_sel(aud1_sel), .aud2_sel(aud2_sel), .aud3_sel(aud3_sel),
    .zc_en(zc_en), .ch3_mute(ch3_mute), .gd_val(gd_val), .vol_coarse(vol_coarse),
    .vol_fine(vol_fine), .lr_route(lr_route), .gd1_en(gd1_en), .gd2_en(gd2_en),
    .syncsrc1(syncsrc1), .syncsrc2(syncsrc2), .lo0(lo0), .lo1(lo1)
  );

  function automatic logic [7:0] get_byte(input int idx);
    case (idx)
      0: return {cv1_sel, cv2_sel};
      1: return {lo0, lo1, yc1_sel, yc2_sel};
      2: return {zc_en, ch3_mute, aud1_sel, aud2_sel};
      3: return {gd_val, aud3_sel};
      4: return {vol_coarse, vol_fine, lr_route};
      default: return {gd1_en, gd2_en, syncsrc1, syncsrc2, 4'b0000};
    endcase
  endfunction

  function automatic string tag_of(input int idx);
    case (idx)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3, 4: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [7:0] exp_status(input logic s2, input logic s1,
      input logic [1:0] a, input logic [1:0] b, input logic [1:0] c, input logic p);
    int ca, cb, cc;
    ca = (a == 2'd3) ? 2 : int'(a);
    cb = (b == 2'd3) ? 2 : int'(b);
    cc = (c == 2'd3) ? 2 : int'(c);
    return {s2, s1, 5'(ca + 3 * cb + 9 * cc), p};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
    sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0;
    end
    sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
    ack = ~sda_bus;
    scl_m = 1'b0; hold();
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(); scl_m = 1'b1; hold(); b[i] = sda_bus; scl_m = 1'b0;
    end
    sda_m = ~give_ack; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0; hold();
    sda_m = 1'b1;
  endtask

  task automatic wr_seq(input logic [7:0] a, input logic [7:0] sub, input int n,
      input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2, output logic all_ack);
    logic ak;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    i2c_start();
    wbyte(a, ak);
    all_ack = ak;
    if (ak) begin
      wbyte(sub, ak); all_ack &= ak;
      for (int i = 0; i < n; i++) begin wbyte(d[i], ak); all_ack &= ak; end
    end
    i2c_stop();
    hold();
  endtask

  task automatic model_wr(input logic [7:0] sub, input logic [7:0] d);
    if (sub < 8'd6) mdl[sub] = (sub == 8'd5) ? (d & 8'hF0) : d;
  endtask

  task automatic chk_all(input string why);
    for (int i = 0; i < 6; i++)
      chk($sformatf("%s %s byte%0d", tag_of(i), why, i), 32'(get_byte(i)), 32'(mdl[i]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R13 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ak, ak2;
    logic [7:0] rb, rb2;
    mdl[0] = 8'h99; mdl[1] = 8'hFF; mdl[2] = 8'hFF;
    mdl[3] = 8'h87; mdl[4] = 8'hFC; mdl[5] = 8'hF0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    hold();
    // R9 reset image
    for (int i = 0; i < 6; i++)
      chk($sformatf("R9 reset byte%0d", i), 32'(get_byte(i)), 32'(mdl[i]));
    chk("R13 sda released at reset", 32'(sda_oe), 32'd0);

    // R10 R11 R12: status after reset
    mode1 = 2'd1; mode2 = 2'd2; mode3 = 2'd0; sync1_det = 1'b1; sync2_det = 1'b0;
    hold();
    i2c_start(); wbyte(8'h91, ak); rbyte(1'b0, rb); i2c_stop();
    chk("R1 read address ack", 32'(ak), 32'd1);
    chk("R10 R11 R12 status after reset", 32'(rb), 32'(exp_status(0, 1, 1, 2, 0, 1)));

    // R1: wrong address is not acknowledged and changes nothing
    wr_seq(8'h92, 8'd0, 1, 8'h00, 8'h00, 8'h00, ak);
    chk("R1 foreign address nack", 32'(ak), 32'd0);
    chk_all("R1 foreign write ignored");
    i2c_start(); wbyte(8'h91, ak); rbyte(1'b0, rb); i2c_stop();
    chk("R1 R12 flag kept after foreign write", 32'(rb[0]), 32'd1);

    // R2..R8, R13: table walk, one data byte per transfer
    for (int v = 0; v < NV; v++) begin
      wr_seq(8'h90, VEC[v][15:8], 1, VEC[v][7:0], 8'h00, 8'h00, ak);
      chk($sformatf("R2 write %0d acked", v), 32'(ak), 32'd1);
      model_wr(VEC[v][15:8], VEC[v][7:0]);
      chk_all((VEC[v][15:8] >= 8'd6) ? "R3 out-of-range ignored" : "R2 table");
    end

    // R2 R3: auto-increment across the end of the bank
    wr_seq(8'h90, 8'd4, 3, 8'hA4, 8'h9F, 8'h77, ak);
    chk("R3 all bytes acked", 32'(ak), 32'd1);
    model_wr(8'd4, 8'hA4); model_wr(8'd5, 8'h9F);
    chk_all("R2 auto-increment");

    // R10 R11 R12: two-byte read, values 3 clamp
    mode1 = 2'd3; mode2 = 2'd3; mode3 = 2'd3; sync1_det = 1'b1; sync2_det = 1'b1;
    hold();
    i2c_start(); wbyte(8'h91, ak); rbyte(1'b1, rb); rbyte(1'b0, rb2); i2c_stop();
    chk("R11 R12 clamped status byte 1", 32'(rb), 32'(exp_status(1, 1, 3, 3, 3, 0)));
    chk("R10 repeated status byte 2", 32'(rb2), 32'(exp_status(1, 1, 3, 3, 3, 0)));
    chk("R10 bus released after nack", 32'(sda_oe), 32'd0);

    mode1 = 2'd0; mode2 = 2'd1; mode3 = 2'd2; sync1_det = 1'b0; sync2_det = 1'b0;
    hold();
    i2c_start(); wbyte(8'h91, ak); rbyte(1'b0, rb); i2c_stop();
    chk("R11 mixed modes", 32'(rb), 32'(exp_status(0, 0, 0, 1, 2, 0)));

    // R1: address select pin high
    addr_sel = 1'b1;
    hold();
    wr_seq(8'h90, 8'd0, 1, 8'h55, 8'h00, 8'h00, ak);
    chk("R1 old address nack", 32'(ak), 32'd0);
    wr_seq(8'h92, 8'd0, 1, 8'h34, 8'h00, 8'h00, ak2);
    chk("R1 new address ack", 32'(ak2), 32'd1);
    model_wr(8'd0, 8'h34);
    chk_all("R1 R4 after address change");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule